// File: doc/BRIEF.md
# Lane Receive Elastic Buffer with Lock and Fill Status

This block sits behind the frame synchronizer of one serial lane. The lane delivers 66-bit words, each a 2-bit sync header and a 64-bit payload. Every accepted word goes into a small first-in first-out store. Nothing is dropped by header type, so framing words (sync, scrambler state, skip, diagnostic) still reach the alignment logic further on. On the read side the block returns the payload with a one-bit control flag derived from the header. It also reports a header-error pulse, a sticky overflow flag, a partially-empty flag compared against a programmable threshold, a combined block/frame lock status, and registered copies of the metaframe-lock and first-sync-seen indications.

The consumer is expected to drive the read enable from the inverse of the partially-empty flag. It starts reading once enough words are buffered and stops when the fill level falls under the threshold again. After an overflow, a flush input empties the store and clears the overflow flag. The whole block uses one clock with a synchronous active-low reset.

Top module: `lane_rx_fifo`

## Requirements
- R1: A word written with header 2'b01 is read back with `out_ctrl`=0, and one written with header 2'b10 with `out_ctrl`=1. The payload is returned unchanged, and words come out in write order.
- R2: A word with header 2'b00 or 2'b11 is still stored and read back with `out_ctrl`=1. `out_hdr_err` is high for exactly the cycle in which that word is presented, and is low at all other times.
- R3: A write (`in_valid`=1) made while the store holds DEPTH words is discarded, even if a read happens in the same cycle. `out_overflow` is high from the following cycle and stays high until a flush.
- R4: A flush empties the store and clears `out_overflow` and `out_valid` at the next clock edge. Reads and writes offered in the flush cycle are ignored, and `out_mf_lock` and `out_sync_seen` are not changed by the flush.
- R5: `out_pempty` is high exactly when the fill level is strictly below `thresh`, and low when the level equals or exceeds it. It reflects the fill level after the most recent clock edge.
- R6: `out_lock` equals `lock_in` registered one cycle, except that it is low in the cycle after any cycle in which the store was empty.
- R7: `out_mf_lock` and `out_sync_seen` are `mf_lock_in` and `sync_seen_in` registered one cycle. An empty store has no effect on them.
- R8: A read enable while the store is empty returns nothing (`out_valid` stays low), and the read position does not advance. The next word written is the next word read.
- R9: A read accepted at one clock edge presents its word with `out_valid`=1 after that edge. A read and a write in the same cycle on a store that is neither empty nor full both take effect, and the fill level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming word is present |
| in_hdr | input | 2 | Sync header of the incoming word |
| in_payload | input | DATA_W | Payload of the incoming word |
| lock_in | input | 1 | Block and frame lock from the synchronizer |
| mf_lock_in | input | 1 | Metaframe lock from the synchronizer |
| sync_seen_in | input | 1 | First sync word seen, from the synchronizer |
| thresh | input | CNT_W | Partially-empty threshold in words |
| rd_en | input | 1 | Read request |
| flush | input | 1 | Empty the store and clear overflow |
| out_valid | output | 1 | Output word is valid this cycle |
| out_payload | output | DATA_W | Payload of the word read |
| out_ctrl | output | 1 | 1 for a control/burst/idle word, 0 for data |
| out_hdr_err | output | 1 | Word read carried an invalid header |
| out_overflow | output | 1 | Sticky overflow indication |
| out_pempty | output | 1 | Fill level below threshold |
| out_lock | output | 1 | Combined lock status, dropped on empty |
| out_mf_lock | output | 1 | Registered metaframe lock |
| out_sync_seen | output | 1 | Registered first-sync-seen |

## Verification
Two collisions are provoked on purpose. The first is a read and a write in the same cycle: on a partly filled store this must keep the fill level constant and keep order, while on a full store the write must be dropped and overflow raised even though the read frees a slot. The second is a flush arriving together with read, write and status activity: the bench checks that overflow and valid clear, that the fill level goes to zero through the partially-empty flag, and that the metaframe and sync-seen flags keep their input values. A cycle-level reference queue in the bench predicts every output after every edge, and the threshold and fill sweep covers all threshold and fill-level pairs of a four-entry store.

// File: rtl/lane_rx_pkg.sv
// Package: shared types for the lane receive buffer.
// Assumes a 2-bit sync header; only 2'b01 and 2'b10 are legal codes.
package lane_rx_pkg;

    typedef enum logic [1:0] {
        SH_BAD_LO = 2'b00,
        SH_DATA   = 2'b01,
        SH_CTRL   = 2'b10,
        SH_BAD_HI = 2'b11
    } sync_hdr_e;

    typedef struct packed {
        logic is_ctrl;
        logic is_bad;
    } hdr_class_t;

endpackage

// File: rtl/lane_rx_hdr_class.sv
// Header classifier: turns a 2-bit sync header into a control flag and
// an error flag. Invalid codes are treated as control and flagged bad.
// Assumes pure combinational use on the read path.
module lane_rx_hdr_class
    import lane_rx_pkg::*;
(
    input  logic [1:0] hdr,
    output hdr_class_t cls
);

    // Map each header code to its classification.
    always_comb begin
        case (sync_hdr_e'(hdr))
            SH_DATA: begin
                cls.is_ctrl = 1'b0;
                cls.is_bad  = 1'b0;
            end
            SH_CTRL: begin
                cls.is_ctrl = 1'b1;
                cls.is_bad  = 1'b0;
            end
            default: begin
                cls.is_ctrl = 1'b1;
                cls.is_bad  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/lane_rx_store.sv
// Word store: circular buffer of DEPTH entries with an occupancy count.
// A write is accepted only when the count is below DEPTH (judged on the
// count before the edge). A read is accepted only when the count is non-zero.
// Flush overrides both and zeroes the pointers and the count.
// Assumes DEPTH >= 2; DEPTH need not be a power of two.
module lane_rx_store #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 66,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_req,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_req,
    output logic [WORD_W-1:0] rd_word,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic              wr_drop,
    output logic [CNT_W-1:0]  occ
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rptr;
    logic              full;
    logic              empty;

    assign full    = (occ == FULL_CNT);
    assign empty   = (occ == '0);
    assign wr_ok   = wr_req && !full && !flush;
    assign rd_ok   = rd_req && !empty && !flush;
    assign wr_drop = wr_req && full && !flush;
    assign rd_word = mem[rptr];

    // Store accepted words; entries need no reset.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wptr] <= wr_word;
        end
    end

    // Advance the write pointer with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
        end else if (wr_ok) begin
            wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
        end
    end

    // Advance the read pointer with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rptr <= '0;
        end else if (rd_ok) begin
            rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
        end
    end

    // Track how many words are held.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            occ <= '0;
        end else begin
            case ({wr_ok, rd_ok})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

endmodule

// File: rtl/lane_rx_status.sv
// Status unit: sticky overflow, partially-empty compare, lock status that
// drops the cycle after an empty store, and registered pass-through
// flags that empty and flush leave untouched.
// Assumes occ is the registered occupancy from the store.
module lane_rx_status #(
    parameter int CNT_W  = 4,
    parameter int FLAG_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_drop,
    input  logic [CNT_W-1:0]  occ,
    input  logic [CNT_W-1:0]  thresh,
    input  logic              lock_in,
    input  logic [FLAG_N-1:0] flag_in,
    output logic              ovf,
    output logic              pempty,
    output logic              lock_out,
    output logic [FLAG_N-1:0] flag_out
);

    assign pempty = (occ < thresh);

    // Hold overflow until a flush clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ovf <= 1'b0;
        end else if (wr_drop) begin
            ovf <= 1'b1;
        end
    end

    // Lock follows its input but is cleared after an empty cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_out <= 1'b0;
        end else begin
            lock_out <= lock_in && (occ != '0);
        end
    end

    // One register per pass-through flag; flush does not reach them.
    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        logic q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= 1'b0;
            end else begin
                q <= flag_in[g];
            end
        end
        assign flag_out[g] = q;
    end

endmodule

// File: rtl/lane_rx_fifo.sv
// Lane receive buffer top: stores header plus payload, classifies the
// header on the way out through a registered read stage, and gathers the
// status outputs. Single clock, synchronous active-low reset.
// Assumes the consumer reads in response to out_pempty going low.
module lane_rx_fifo
    import lane_rx_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_hdr,
    input  logic [DATA_W-1:0] in_payload,
    input  logic              lock_in,
    input  logic              mf_lock_in,
    input  logic              sync_seen_in,
    input  logic [CNT_W-1:0]  thresh,
    input  logic              rd_en,
    input  logic              flush,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_payload,
    output logic              out_ctrl,
    output logic              out_hdr_err,
    output logic              out_overflow,
    output logic              out_pempty,
    output logic              out_lock,
    output logic              out_mf_lock,
    output logic              out_sync_seen
);

    localparam int WORD_W = DATA_W + 2;
    localparam int FLAG_N = 2;

    logic [WORD_W-1:0] rd_word;
    logic              wr_ok;
    logic              rd_ok;
    logic              wr_drop;
    logic [CNT_W-1:0]  occ;
    hdr_class_t        rd_cls;
    logic [FLAG_N-1:0] flags_q;

    lane_rx_store #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_req  (in_valid),
        .wr_word ({in_hdr, in_payload}),
        .rd_req  (rd_en),
        .rd_word (rd_word),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .wr_drop (wr_drop),
        .occ     (occ)
    );

    lane_rx_hdr_class u_class (
        .hdr (rd_word[WORD_W-1 -: 2]),
        .cls (rd_cls)
    );

    lane_rx_status #(
        .CNT_W  (CNT_W),
        .FLAG_N (FLAG_N)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_drop  (wr_drop),
        .occ      (occ),
        .thresh   (thresh),
        .lock_in  (lock_in),
        .flag_in  ({sync_seen_in, mf_lock_in}),
        .ovf      (out_overflow),
        .pempty   (out_pempty),
        .lock_out (out_lock),
        .flag_out (flags_q)
    );

    assign out_mf_lock   = flags_q[0];
    assign out_sync_seen = flags_q[1];

    // Read stage: present the word taken at this edge for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_payload <= '0;
            out_ctrl    <= 1'b0;
            out_hdr_err <= 1'b0;
        end else begin
            out_valid   <= rd_ok;
            out_hdr_err <= rd_ok && rd_cls.is_bad;
            if (rd_ok) begin
                out_payload <= rd_word[DATA_W-1:0];
                out_ctrl    <= rd_cls.is_ctrl;
            end
        end
    end

    // The write-accept strobe is consumed inside the store only.
    logic unused_wr_ok;
    assign unused_wr_ok = wr_ok;

endmodule

// File: rtl/lane_rx_fifo_chk.sv
// Checker for lane_rx_fifo: temporal properties on ports and occupancy.
// Attached by the bind statement at the end of this file.
module lane_rx_fifo_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             rd_en,
    input logic             flush,
    input logic             mf_lock_in,
    input logic             sync_seen_in,
    input logic [CNT_W-1:0] thresh,
    input logic [CNT_W-1:0] occ,
    input logic             out_valid,
    input logic             out_ctrl,
    input logic             out_hdr_err,
    input logic             out_overflow,
    input logic             out_pempty,
    input logic             out_lock,
    input logic             out_mf_lock,
    input logic             out_sync_seen
);

    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

    assert_hdr_err_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_hdr_err |-> (out_valid && out_ctrl));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && occ == FULL_C && !flush) |=> out_overflow);

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_overflow && !flush) |=> out_overflow);

    assert_flush_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!out_overflow && !out_valid && occ == '0));

    assert_flush_keeps_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (out_mf_lock == $past(mf_lock_in) && out_sync_seen == $past(sync_seen_in)));

    assert_pempty_low_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && thresh != '0) |-> out_pempty);

    assert_pempty_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == FULL_C && thresh <= FULL_C) |-> !out_pempty);

    assert_lock_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |=> !out_lock);

    assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && occ == '0) |=> !out_valid);

    assert_read_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !flush && occ != '0) |=> out_valid);

    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_C);

endmodule

bind lane_rx_fifo lane_rx_fifo_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .rd_en         (rd_en),
    .flush         (flush),
    .mf_lock_in    (mf_lock_in),
    .sync_seen_in  (sync_seen_in),
    .thresh        (thresh),
    .occ           (occ),
    .out_valid     (out_valid),
    .out_ctrl      (out_ctrl),
    .out_hdr_err   (out_hdr_err),
    .out_overflow  (out_overflow),
    .out_pempty    (out_pempty),
    .out_lock      (out_lock),
    .out_mf_lock   (out_mf_lock),
    .out_sync_seen (out_sync_seen)
);

// File: tb/tb_lane_rx_fifo.sv
`timescale 1ns/1ps
// Bench: cycle-level reference queue predicts every output after every
// edge; sweeps all header codes and all threshold/fill pairs of a
// four-entry store, plus overflow, flush, empty-read and lock cases.
module tb_lane_rx_fifo;

    localparam int D  = 4;
    localparam int CW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [1:0]    in_hdr;
    logic [63:0]   in_payload;
    logic          lock_in;
    logic          mf_lock_in;
    logic          sync_seen_in;
    logic [CW-1:0] thresh;
    logic          rd_en;
    logic          flush;
    logic          out_valid;
    logic [63:0]   out_payload;
    logic          out_ctrl;
    logic          out_hdr_err;
    logic          out_overflow;
    logic          out_pempty;
    logic          out_lock;
    logic          out_mf_lock;
    logic          out_sync_seen;

    int total = 0;
    int bad   = 0;
    logic [65:0] q[$];
    logic        m_ovf = 1'b0;

    always #10 clk = ~clk;

    lane_rx_fifo #(.DEPTH(D), .DATA_W(64)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr),
        .in_payload(in_payload), .lock_in(lock_in), .mf_lock_in(mf_lock_in),
        .sync_seen_in(sync_seen_in), .thresh(thresh), .rd_en(rd_en),
        .flush(flush), .out_valid(out_valid), .out_payload(out_payload),
        .out_ctrl(out_ctrl), .out_hdr_err(out_hdr_err),
        .out_overflow(out_overflow), .out_pempty(out_pempty),
        .out_lock(out_lock), .out_mf_lock(out_mf_lock),
        .out_sync_seen(out_sync_seen)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int i);
        return 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15);
    endfunction

    // One clock: drive at negedge, predict, then compare at next negedge.
    task automatic cyc(input logic wr, input logic [1:0] h, input logic [63:0] p,
                       input logic rd, input logic fl);
        logic        exp_v;
        logic        exp_lock;
        logic [65:0] w;
        int          old;
        old = q.size();
        in_valid = wr; in_hdr = h; in_payload = p; rd_en = rd; flush = fl;
        exp_v = 1'b0;
        w = '0;
        exp_lock = lock_in && (old != 0);
        if (fl) begin
            q.delete();
            m_ovf = 1'b0;
        end else begin
            if (rd && old > 0) begin
                w = q.pop_front();
                exp_v = 1'b1;
            end
            if (wr) begin
                if (old < D) q.push_back({h, p});
                else m_ovf = 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; rd_en = 1'b0; flush = 1'b0;
        chk("R8 R9 out_valid", 64'(out_valid), 64'(exp_v));
        if (exp_v) begin
            chk("R1 payload", out_payload, w[63:0]);
            chk("R1 R2 ctrl flag", 64'(out_ctrl), 64'(w[65:64] != 2'b01));
            chk("R2 header error", 64'(out_hdr_err),
                64'(w[65:64] == 2'b00 || w[65:64] == 2'b11));
        end else begin
            chk("R2 header error idle", 64'(out_hdr_err), 64'd0);
        end
        chk("R3 overflow", 64'(out_overflow), 64'(m_ovf));
        chk("R5 pempty", 64'(out_pempty), 64'(q.size() < int'(thresh)));
        chk("R6 lock", 64'(out_lock), 64'(exp_lock));
        chk("R7 mf lock", 64'(out_mf_lock), 64'(mf_lock_in));
        chk("R7 sync seen", 64'(out_sync_seen), 64'(sync_seen_in));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_hdr = 2'b01; in_payload = '0;
        lock_in = 1'b0; mf_lock_in = 1'b0; sync_seen_in = 1'b0;
        thresh = CW'(2); rd_en = 1'b0; flush = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 reset valid", 64'(out_valid), 64'd0);
        chk("R3 reset overflow", 64'(out_overflow), 64'd0);
        chk("R6 reset lock", 64'(out_lock), 64'd0);
        chk("R5 reset pempty", 64'(out_pempty), 64'd1);
        chk("R7 reset mf lock", 64'(out_mf_lock), 64'd0);

        lock_in = 1'b1; mf_lock_in = 1'b1; sync_seen_in = 1'b1;

        // R1 R2: every header code, several payloads, write then read.
        for (int h = 0; h < 4; h++) begin
            for (int k = 0; k < 3; k++) begin
                cyc(1'b1, 2'(h), pat(h * 3 + k), 1'b0, 1'b0);
                cyc(1'b0, 2'b01, '0, 1'b1, 1'b0);
            end
        end

        // R5: every threshold against every fill level.
        for (int t = 0; t <= D; t++) begin
            thresh = CW'(t);
            cyc(1'b0, 2'b01, '0, 1'b0, 1'b1);
            for (int n = 0; n < D; n++) begin
                cyc(1'b1, 2'b10, pat(100 + n), 1'b0, 1'b0);
            end
            chk("R5 full store vs threshold", 64'(out_pempty), 64'(D < t));
        end

        // R3: overflow on full store, incl. simultaneous read; order kept.
        thresh = CW'(1);
        cyc(1'b0, 2'b01, '0, 1'b0, 1'b1);
        for (int n = 0; n < D; n++) cyc(1'b1, 2'b01, pat(200 + n), 1'b0, 1'b0);
        cyc(1'b1, 2'b01, pat(299), 1'b1, 1'b0);
        chk("R3 overflow on full with read", 64'(out_overflow), 64'd1);
        cyc(1'b1, 2'b10, pat(298), 1'b0, 1'b0);
        for (int n = 0; n < D + 1; n++) cyc(1'b0, 2'b01, '0, 1'b1, 1'b0);
        chk("R3 overflow sticky", 64'(out_overflow), 64'd1);

        // R4: flush with read and write pending; flags keep their inputs.
        cyc(1'b1, 2'b01, pat(300), 1'b0, 1'b0);
        cyc(1'b1, 2'b10, pat(301), 1'b1, 1'b1);
        chk("R4 overflow cleared", 64'(out_overflow), 64'd0);
        chk("R4 store emptied", 64'(out_pempty), 64'd1);
        chk("R4 mf lock kept", 64'(out_mf_lock), 64'd1);

        // R8: empty reads do not move the read position.
        cyc(1'b0, 2'b01, '0, 1'b1, 1'b0);
        cyc(1'b0, 2'b01, '0, 1'b1, 1'b0);
        cyc(1'b1, 2'b11, pat(400), 1'b0, 1'b0);
        cyc(1'b0, 2'b01, '0, 1'b1, 1'b0);
        chk("R8 word after empty reads", out_payload, pat(400));

        // R9: concurrent read and write on a partly filled store.
        cyc(1'b1, 2'b01, pat(500), 1'b0, 1'b0);
        for (int n = 1; n < 6; n++) cyc(1'b1, 2'(n % 4), pat(500 + n), 1'b1, 1'b0);
        chk("R9 fill steady", 64'(out_pempty), 64'd0);
        cyc(1'b0, 2'b01, '0, 1'b1, 1'b0);

        // R6 R7: lock drops after empty, metaframe flags stay.
        cyc(1'b0, 2'b01, '0, 1'b0, 1'b0);
        chk("R6 lock low after empty", 64'(out_lock), 64'd0);
        chk("R7 sync seen held", 64'(out_sync_seen), 64'd1);
        mf_lock_in = 1'b0;
        cyc(1'b1, 2'b10, pat(600), 1'b0, 1'b0);
        cyc(1'b0, 2'b01, '0, 1'b0, 1'b0);
        chk("R6 lock back with data", 64'(out_lock), 64'd1);
        chk("R7 mf lock follows input", 64'(out_mf_lock), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule